// File: doc/BRIEF.md
# Composite Video Field Timing Generator

This block produces a repeating two-field monochrome composite video sequence in the style of a 625-line interlaced system. The output is a 3-bit drive-strength code, not a DAC sample. Code 0 is the sync tip, code 1 is black, and the higher odd codes are brighter picture levels. An external one-microsecond tick enable paces the sequence. Every tick moves the waveform forward by one position. Between ticks the block holds all of its outputs.

Each field starts with a vertical interval of three groups of 32-tick pairs: pre-equalisation pairs, then broad sync pairs, then post-equalisation pairs. The active lines follow. Each active line carries a horizontal sync, a back porch, 52 picture samples and a front porch. The first field has 304 active lines and the second has 305. After the last line of the second field the sequence returns to the first field with no gap.

Picture samples come from a small on-chip picture store. Software-side logic writes it one pixel at a time through a separate port, giving a source line number and a raw pixel value. The block converts each value to a drive code and places even source lines in the first field and odd source lines in the second. The store holds `MEM_LINES` lines per field, and active line `l` shows stored line `l mod MEM_LINES`. Alongside the level, the block reports:
- a frame-start strobe;
- the active field;
- the active line and sample indices.

Top module: `vid_field_timer`

## Requirements
- R1: While reset is asserted, and after its release until the first tick, `levelOut` is 1, `frameStart` and `sampleActive` are 0, and `fieldId`, `lineIdx` and `sampleIdx` are 0.
- R2: A field begins with 6 pre-equalisation pairs. Each pair is 2 ticks at level 0 followed by 30 ticks at level 1.
- R3: Next come 5 broad sync pairs. Each pair is 30 ticks at level 0 followed by 2 ticks at level 1.
- R4: Then come 5 post-equalisation pairs, timed the same way as the pre-equalisation pairs (2 ticks at 0, then 30 ticks at 1).
- R5: An active line is 64 ticks: ticks 0-3 at level 0, ticks 4-9 at level 1, ticks 10-61 as samples, and ticks 62-63 at level 1. During tick 10+s, `sampleActive` is 1 and `sampleIdx` is s. Outside the sample ticks, `sampleActive` and `sampleIdx` are 0.
- R6: Field 0 (`fieldId`=0) has 304 active lines and field 1 has 305. `lineIdx` gives the active line number during active lines and is 0 during the vertical interval. A whole frame takes 40000 ticks, and then the sequence wraps to field 0 with no gap.
- R7: A pixel value v is stored as the code (6*v+1) mod 8.
- R8: A pixel written with source line n goes to field n mod 2, stored line floor(n/2). Sample s of active line l in field f shows the code stored for field f, stored line l mod `MEM_LINES`, sample s.
- R9: Outputs change only on the clock edge that samples `tickEn` high. In every other cycle all outputs hold their values.
- R10: `frameStart` is high for exactly one cycle, in the cycle after the tick that shows the first pre-equalisation tick of field 0 (tick 0 of each frame). It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle advance enable, one per microsecond |
| wrEn | input | 1 | Picture store write strobe |
| wrSrcLine | input | 4 | Source line number for the write (bit 0 selects the field) |
| wrSample | input | 6 | Sample position 0..51 for the write |
| wrPixel | input | 8 | Raw pixel value to convert and store |
| levelOut | output | 3 | Drive-strength code: 0 sync, 1 black, odd codes picture |
| frameStart | output | 1 | One-cycle strobe at the start of each frame |
| fieldId | output | 1 | Field currently shown |
| lineIdx | output | 9 | Active line number within the field |
| sampleIdx | output | 6 | Sample number within the active line |
| sampleActive | output | 1 | High while a picture sample is shown |

## Verification
The hardest point to reach is the 305th line of the second field and the return from it to the first pre-equalisation pair. From the ports, this point arrives only after nearly 40000 ticks. To reach it, the bench asserts the tick on every clock cycle and compares every tick, including the wrap, against a model of the frame built from position arithmetic. The read-ahead path from the picture store is most exposed when ticks arrive back to back. For that reason, the free-running pass comes first. A later pass spaces the ticks apart to exercise the hold behaviour. The picture store is filled with values whose codes differ for every field, stored line and sample, so that a wrong field, line or sample mapping shows up as a level mismatch.

// File: rtl/vft_pkg.sv
package vft_pkg;

  localparam int LVL_W = 3;

  typedef enum logic [1:0] {
    PH_PRE    = 2'd0,
    PH_BROAD  = 2'd1,
    PH_POST   = 2'd2,
    PH_ACTIVE = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    LV_SYNC  = 2'd0,
    LV_BLACK = 2'd1,
    LV_PIXEL = 2'd2
  } lvlKind_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic     adv;    // advance on this cycle
    lvlKind_e kind;   // kind of the position being presented
    logic     fetch;  // following position is a picture sample
  } strobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vft_ctrl.sv
module vft_ctrl
  import vft_pkg::*;
#(
  parameter int PRE_PAIRS   = 6,
  parameter int BROAD_PAIRS = 5,
  parameter int POST_PAIRS  = 5,
  parameter int PAIR_LEN    = 32,
  parameter int EQ_LOW      = 2,
  parameter int BROAD_LOW   = 30,
  parameter int HSYNC       = 4,
  parameter int BACK        = 6,
  parameter int SAMPLES     = 52,
  parameter int FRONT       = 2,
  parameter int LINES_F0    = 304,
  parameter int LINES_F1    = 305,
  parameter int MEM_LINES   = 8,
  localparam int LINE_LEN   = HSYNC + BACK + SAMPLES + FRONT,
  localparam int CNT_W      = $clog2(maxOf(PAIR_LEN, LINE_LEN)),
  localparam int IDX_W      = $clog2(maxOf(maxOf(LINES_F0, LINES_F1),
                                     maxOf(PRE_PAIRS, maxOf(BROAD_PAIRS, POST_PAIRS))) + 1),
  localparam int SMP_W      = $clog2(SAMPLES),
  localparam int ML_W       = $clog2(MEM_LINES),
  localparam int DEPTH      = 2 * MEM_LINES * SAMPLES,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  output strobe_t          stb,
  output logic [AW-1:0]    rdAddr,
  output logic             fieldId,
  output logic [IDX_W-1:0] lineIdx,
  output logic [SMP_W-1:0] sampleIdx,
  output logic             sampleActive,
  output logic             frameStart
);

  localparam logic [CNT_W-1:0] PAIR_LAST  = CNT_W'(PAIR_LEN - 1);
  localparam logic [CNT_W-1:0] LINE_LAST  = CNT_W'(LINE_LEN - 1);
  localparam logic [CNT_W-1:0] EQ_LOW_C   = CNT_W'(EQ_LOW);
  localparam logic [CNT_W-1:0] BROAD_C    = CNT_W'(BROAD_LOW);
  localparam logic [CNT_W-1:0] HSYNC_C    = CNT_W'(HSYNC);
  localparam logic [CNT_W-1:0] PIX_START  = CNT_W'(HSYNC + BACK);
  localparam logic [CNT_W-1:0] PIX_END    = CNT_W'(HSYNC + BACK + SAMPLES);
  localparam logic [IDX_W-1:0] PRE_LAST   = IDX_W'(PRE_PAIRS - 1);
  localparam logic [IDX_W-1:0] BROAD_LAST = IDX_W'(BROAD_PAIRS - 1);
  localparam logic [IDX_W-1:0] POST_LAST  = IDX_W'(POST_PAIRS - 1);
  localparam logic [IDX_W-1:0] F0_LAST    = IDX_W'(LINES_F0 - 1);
  localparam logic [IDX_W-1:0] F1_LAST    = IDX_W'(LINES_F1 - 1);
  localparam logic [IDX_W-1:0] LINE_MAX   = IDX_W'(maxOf(LINES_F0, LINES_F1) - 1);
  localparam logic [SMP_W-1:0] SMP_LAST   = SMP_W'(SAMPLES - 1);
  localparam logic [AW-1:0]    FIELD_BASE = AW'(MEM_LINES * SAMPLES);

  // position that the next tick will present
  phase_e           phase, phaseN;
  logic             fld, fldN;
  logic [IDX_W-1:0] idx, idxN;
  logic [CNT_W-1:0] cnt, cntN;
  logic [CNT_W-1:0] lastCnt;
  logic [IDX_W-1:0] lastLine;
  logic [CNT_W-1:0] smpNow, smpNext;
  lvlKind_e         kindNow, kindNext;

  function automatic lvlKind_e kindOf(input phase_e p, input logic [CNT_W-1:0] c);
    lvlKind_e k;
    unique case (p)
      PH_BROAD:  k = (c < BROAD_C) ? LV_SYNC : LV_BLACK;
      PH_ACTIVE: begin
        if (c < HSYNC_C)        k = LV_SYNC;
        else if (c < PIX_START) k = LV_BLACK;
        else if (c < PIX_END)   k = LV_PIXEL;
        else                    k = LV_BLACK;
      end
      default:   k = (c < EQ_LOW_C) ? LV_SYNC : LV_BLACK;
    endcase
    return k;
  endfunction

  always_comb begin
    lastCnt  = (phase == PH_ACTIVE) ? LINE_LAST : PAIR_LAST;
    lastLine = fld ? F1_LAST : F0_LAST;
    phaseN   = phase;
    fldN     = fld;
    idxN     = idx;
    cntN     = cnt + CNT_W'(1);
    if (cnt == lastCnt) begin
      cntN = '0;
      idxN = idx + IDX_W'(1);
      unique case (phase)
        PH_PRE:   if (idx == PRE_LAST)   begin phaseN = PH_BROAD;  idxN = '0; end
        PH_BROAD: if (idx == BROAD_LAST) begin phaseN = PH_POST;   idxN = '0; end
        PH_POST:  if (idx == POST_LAST)  begin phaseN = PH_ACTIVE; idxN = '0; end
        default:  if (idx == lastLine)   begin phaseN = PH_PRE;    idxN = '0; fldN = ~fld; end
      endcase
    end
  end

  always_comb begin
    kindNow   = kindOf(phase, cnt);
    kindNext  = kindOf(phaseN, cntN);
    smpNow    = cnt - PIX_START;
    smpNext   = cntN - PIX_START;
    stb.adv   = tickEn;
    stb.kind  = kindNow;
    stb.fetch = (kindNext == LV_PIXEL);
    rdAddr    = (fldN ? FIELD_BASE : '0)
              + AW'(idxN[ML_W-1:0]) * AW'(SAMPLES)
              + AW'(smpNext);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_PRE;
      fld   <= 1'b0;
      idx   <= '0;
      cnt   <= '0;
    end else if (tickEn) begin
      phase <= phaseN;
      fld   <= fldN;
      idx   <= idxN;
      cnt   <= cntN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fieldId      <= 1'b0;
      lineIdx      <= '0;
      sampleIdx    <= '0;
      sampleActive <= 1'b0;
      frameStart   <= 1'b0;
    end else begin
      frameStart <= tickEn && (phase == PH_PRE) && (idx == '0) && (cnt == '0) && !fld;
      if (tickEn) begin
        fieldId      <= fld;
        lineIdx      <= (phase == PH_ACTIVE) ? idx : '0;
        sampleActive <= (kindNow == LV_PIXEL);
        sampleIdx    <= (kindNow == LV_PIXEL) ? SMP_W'(smpNow) : '0;
      end
    end
  end

  AST_FRAME_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart); // R10
  AST_FRAME_IN_FIELD0: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (!fieldId && lineIdx == '0 && !sampleActive)); // R10
  AST_SAMPLE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    sampleActive |-> (sampleIdx <= SMP_LAST)); // R5
  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    lineIdx <= LINE_MAX); // R6
  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> ($stable(lineIdx) && $stable(sampleIdx) && $stable(fieldId))); // R9

endmodule

// File: rtl/vft_datapath.sv
module vft_datapath
  import vft_pkg::*;
#(
  parameter int SAMPLES   = 52,
  parameter int MEM_LINES = 8,
  parameter int PIX_W     = 8,
  localparam int SMP_W    = $clog2(SAMPLES),
  localparam int ML_W     = $clog2(MEM_LINES),
  localparam int SRC_W    = ML_W + 1,
  localparam int DEPTH    = 2 * MEM_LINES * SAMPLES,
  localparam int AW       = $clog2(DEPTH),
  localparam int PROD_W   = PIX_W + 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [AW-1:0]    rdAddr,
  input  logic             wrEn,
  input  logic [SRC_W-1:0] wrSrcLine,
  input  logic [SMP_W-1:0] wrSample,
  input  logic [PIX_W-1:0] wrPixel,
  output logic [LVL_W-1:0] levelOut
);

  localparam logic [AW-1:0]    FIELD_BASE = AW'(MEM_LINES * SAMPLES);
  localparam logic [LVL_W-1:0] CODE_SYNC  = LVL_W'(0);
  localparam logic [LVL_W-1:0] CODE_BLACK = LVL_W'(1);

  logic [LVL_W-1:0]  store [DEPTH];
  logic [LVL_W-1:0]  rdData;
  logic [PROD_W-1:0] scaled;
  logic [LVL_W-1:0]  wrCode;
  logic [AW-1:0]     wrAddr;
  logic              unusedScaled;

  // value*6+1, low bits kept as the drive code
  always_comb begin
    scaled       = ({3'b000, wrPixel} * PROD_W'(6)) + PROD_W'(1);
    wrCode       = scaled[LVL_W-1:0];
    unusedScaled = ^scaled[PROD_W-1:LVL_W];
    wrAddr       = (wrSrcLine[0] ? FIELD_BASE : '0)
                 + AW'(wrSrcLine[SRC_W-1:1]) * AW'(SAMPLES)
                 + AW'(wrSample);
  end

  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrCode;
  end

  // read issued one tick ahead of the sample it feeds
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= CODE_BLACK;
    end else if (stb.adv && stb.fetch) begin
      rdData <= store[rdAddr];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelOut <= CODE_BLACK;
    end else if (stb.adv) begin
      unique case (stb.kind)
        LV_SYNC:  levelOut <= CODE_SYNC;
        LV_PIXEL: levelOut <= rdData;
        default:  levelOut <= CODE_BLACK;
      endcase
    end
  end

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.adv |=> $stable(levelOut)); // R9
  AST_WRITE_CODE_ODD: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> wrCode[0]); // R7

endmodule

// File: rtl/vid_field_timer.sv
module vid_field_timer
  import vft_pkg::*;
#(
  parameter int PRE_PAIRS   = 6,
  parameter int BROAD_PAIRS = 5,
  parameter int POST_PAIRS  = 5,
  parameter int PAIR_LEN    = 32,
  parameter int EQ_LOW      = 2,
  parameter int BROAD_LOW   = 30,
  parameter int HSYNC       = 4,
  parameter int BACK        = 6,
  parameter int SAMPLES     = 52,
  parameter int FRONT       = 2,
  parameter int LINES_F0    = 304,
  parameter int LINES_F1    = 305,
  parameter int MEM_LINES   = 8,
  parameter int PIX_W       = 8,
  localparam int IDX_W      = $clog2(maxOf(maxOf(LINES_F0, LINES_F1),
                                     maxOf(PRE_PAIRS, maxOf(BROAD_PAIRS, POST_PAIRS))) + 1),
  localparam int SMP_W      = $clog2(SAMPLES),
  localparam int SRC_W      = $clog2(MEM_LINES) + 1,
  localparam int AW         = $clog2(2 * MEM_LINES * SAMPLES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             wrEn,
  input  logic [SRC_W-1:0] wrSrcLine,
  input  logic [SMP_W-1:0] wrSample,
  input  logic [PIX_W-1:0] wrPixel,
  output logic [LVL_W-1:0] levelOut,
  output logic             frameStart,
  output logic             fieldId,
  output logic [IDX_W-1:0] lineIdx,
  output logic [SMP_W-1:0] sampleIdx,
  output logic             sampleActive
);

  strobe_t       stb;
  logic [AW-1:0] rdAddr;

  vft_ctrl #(
    .PRE_PAIRS(PRE_PAIRS), .BROAD_PAIRS(BROAD_PAIRS), .POST_PAIRS(POST_PAIRS),
    .PAIR_LEN(PAIR_LEN), .EQ_LOW(EQ_LOW), .BROAD_LOW(BROAD_LOW),
    .HSYNC(HSYNC), .BACK(BACK), .SAMPLES(SAMPLES), .FRONT(FRONT),
    .LINES_F0(LINES_F0), .LINES_F1(LINES_F1), .MEM_LINES(MEM_LINES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .stb(stb), .rdAddr(rdAddr),
    .fieldId(fieldId), .lineIdx(lineIdx), .sampleIdx(sampleIdx),
    .sampleActive(sampleActive), .frameStart(frameStart)
  );

  vft_datapath #(
    .SAMPLES(SAMPLES), .MEM_LINES(MEM_LINES), .PIX_W(PIX_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(rdAddr),
    .wrEn(wrEn), .wrSrcLine(wrSrcLine), .wrSample(wrSample), .wrPixel(wrPixel),
    .levelOut(levelOut)
  );

  AST_PIXEL_ODD: assert property (@(posedge clk) disable iff (!rstN)
    sampleActive |-> levelOut[0]); // R7
  AST_FRAME_ON_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (levelOut == '0)); // R2

endmodule

// File: tb/vid_field_timer_tb.sv
module vid_field_timer_tb;

  localparam int F0_TICKS    = 512 + 304 * 64;
  localparam int FRAME_TICKS = F0_TICKS + 512 + 305 * 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrSrcLine = '0;
  logic [5:0] wrSample = '0;
  logic [7:0] wrPixel = '0;
  logic [2:0] levelOut;
  logic       frameStart;
  logic       fieldId;
  logic [8:0] lineIdx;
  logic [5:0] sampleIdx;
  logic       sampleActive;

  int nChecks = 0;
  int nFails = 0;
  int tickNo = 0;
  bit finished = 0;

  vid_field_timer u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .wrEn(wrEn), .wrSrcLine(wrSrcLine), .wrSample(wrSample), .wrPixel(wrPixel),
    .levelOut(levelOut), .frameStart(frameStart), .fieldId(fieldId),
    .lineIdx(lineIdx), .sampleIdx(sampleIdx), .sampleActive(sampleActive)
  );

  always #5 clk = ~clk;

  function automatic int pixVal(int f, int ml, int s);
    return (f * 37 + ml * 11 + s * 5) & 255;
  endfunction

  function automatic int codeOf(int v);
    return (v * 6 + 1) % 8;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d (tick %0d)", req, what, act, exp, tickNo);
    end
  endtask

  // expected outputs for display position k within a frame
  task automatic model(input int k, output int lvl, output int fld, output int line,
                       output int sidx, output int sact, output string req);
    int t, c;
    fld = (k < F0_TICKS) ? 0 : 1;
    t = (fld == 0) ? k : k - F0_TICKS;
    line = 0; sidx = 0; sact = 0;
    if (t < 192) begin
      c = t % 32; lvl = (c < 2) ? 0 : 1; req = "R2";
    end else if (t < 352) begin
      c = (t - 192) % 32; lvl = (c < 30) ? 0 : 1; req = "R3";
    end else if (t < 512) begin
      c = (t - 352) % 32; lvl = (c < 2) ? 0 : 1; req = "R4";
    end else begin
      line = (t - 512) / 64; c = (t - 512) % 64; req = "R5";
      if (c < 4) lvl = 0;
      else if (c < 10) lvl = 1;
      else if (c < 62) begin
        sidx = c - 10; sact = 1; req = "R7/R8";
        lvl = codeOf(pixVal(fld, line % 8, sidx));
      end else lvl = 1;
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "level in reset", int'(levelOut), 1);
    chk("R1", "frameStart in reset", int'(frameStart), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "level idle", int'(levelOut), 1);
    chk("R1", "frameStart idle", int'(frameStart), 0);
    chk("R1", "fieldId idle", int'(fieldId), 0);
    chk("R1", "lineIdx idle", int'(lineIdx), 0);
    chk("R1", "sampleIdx idle", int'(sampleIdx), 0);
    chk("R1", "sampleActive idle", int'(sampleActive), 0);
  endtask

  // R7 R8: fill every stored line of both fields through the write port
  task automatic fillStore();
    for (int src = 0; src < 16; src++) begin
      for (int s = 0; s < 52; s++) begin
        wrEn = 1'b1; wrSrcLine = 4'(src); wrSample = 6'(s);
        wrPixel = 8'(pixVal(src % 2, src / 2, s));
        @(negedge clk);
      end
    end
    wrEn = 1'b0;
    @(negedge clk);
    chk("R9", "level unchanged by writes", int'(levelOut), 1);
  endtask

  task automatic runTicks(int n, int gap);
    int lvl, fld, line, sidx, sact, k;
    string req;
    for (int i = 0; i < n; i++) begin
      k = tickNo % FRAME_TICKS;
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
      model(k, lvl, fld, line, sidx, sact, req);
      chk(req, "levelOut", int'(levelOut), lvl);
      chk("R6", "fieldId", int'(fieldId), fld);
      chk("R6", "lineIdx", int'(lineIdx), line);
      chk("R5", "sampleActive", int'(sampleActive), sact);
      chk("R5", "sampleIdx", int'(sampleIdx), sidx);
      chk("R10", "frameStart", int'(frameStart), (k == 0) ? 1 : 0);
      tickNo++;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk("R9", "level hold", int'(levelOut), lvl);
        chk("R9", "index hold", int'({fieldId, lineIdx, sampleIdx, sampleActive}),
            int'({1'(fld), 9'(line), 6'(sidx), 1'(sact)}));
        chk("R10", "frameStart pulse width", int'(frameStart), 0);
      end
    end
  endtask

  initial begin
    testReset();
    fillStore();
    runTicks(FRAME_TICKS + 2000, 0);
    runTicks(400, 2);
    runTicks(200, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule